// File: doc/BRIEF.md
# Two-Register Bit-Serial Accumulating Adder

This block adds binary numbers one bit position per clock using a single full adder. It keeps its working data in two shift registers and one carry flip-flop. Operands arrive least significant bit first on one serial input and shift into the operand register. On every enabled clock, the bit that leaves the low end of the operand register is added to the bit that leaves the low end of the accumulator register and to the stored carry. The sum bit goes back into the top of the accumulator. The accumulator therefore acts as both the second addend and the result.

Each pass of four enabled cycles adds the operand register's contents into the accumulator. During the same cycles, the next operand streams into the operand register. Streaming two operands and then four zero bits therefore leaves their sum in the accumulator after twelve cycles. If the streaming continues, the accumulator keeps a running sum. The carry store can be a D flip-flop or a JK flip-flop, chosen by a parameter, and both give the same carry sequence.

Top module: `serial_accum_adder`

## Requirements
- R1: A synchronous active-high `rst` clears `reg_a`, `reg_b`, `carry_out`, the stored carry and the pass position. The next enabled cycle is then the first cycle of a pass.
- R2: On each cycle with `shift_en` high, `reg_a` shifts right by one and `ser_in` enters at bit 3. After four enabled cycles, `reg_a` holds the operand sent least significant bit first.
- R3: While `shift_en` is low, `reg_a`, `reg_b` and `carry_out` keep their values, and the pass position does not advance.
- R4: On each enabled cycle, `reg_b` shifts right and `reg_a[0] ^ reg_b[0] ^ carry` enters at bit 3. After one pass, `reg_b` equals its old value plus the old `reg_a`, modulo 16.
- R5: The stored carry is cleared at the start of every pass (enabled cycles 1, 5, 9, ...). No carry passes from one pass into the next.
- R6: On the last enabled cycle of each pass, `carry_out` takes the carry out of bit 3 of that pass's addition, and that carry is not added into `reg_b`. At all other times `carry_out` holds its value.
- R7: After reset, streaming 1011 and then 0010 (least significant bit first) followed by four zero bits leaves `reg_b` = 1101 after the twelfth enabled cycle, with `reg_a` = 0000.
- R8: With `USE_JK` = 1, the carry store is a JK flip-flop with J = A0·B0 and K = NOT(A0 + B0). It gives the same `reg_a`, `reg_b` and `carry_out` as the D version for every input sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Advances every register by one bit position |
| ser_in | input | 1 | Serial operand bit, least significant bit first |
| reg_a | output | 4 | Parallel view of the operand register |
| reg_b | output | 4 | Parallel view of the accumulator and result register |
| carry_out | output | 1 | Carry out of the most significant bit of the last completed pass |

## Verification
The bench runs every pair of 4-bit operands through the twelve-cycle sequence on both carry-store variants. It compares the accumulator and `carry_out` against a reference sum. It then accumulates long random operand streams without a reset between passes, with idle cycles inserted between bits, and checks the running total modulo 16.

Each check targets a specific fault:
- If the carry is not cleared at pass boundaries, the top carry of one sum leaks into the low bit of the next.
- If `carry_out` is added back into the accumulator, some results come out off by one.
- If an idle cycle advances the pass counter or any register, the bit alignment is lost.
- A wrong J or K term makes the two variants disagree on operand pairs that carry.

// File: rtl/serial_accum_adder.sv
module serial_accum_adder #(
  parameter int WIDTH  = 4,
  parameter bit USE_JK = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic [WIDTH-1:0] reg_a,
  output logic [WIDTH-1:0] reg_b,
  output logic             carry_out
);
  localparam int PW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(WIDTH - 1);

  logic [PW-1:0] pos;
  logic          carry_q;
  logic          cin, a0, b0, sum_bit, carry_d;

  assign a0      = reg_a[0];
  assign b0      = reg_b[0];
  assign cin     = (pos == '0) ? 1'b0 : carry_q;
  assign sum_bit = a0 ^ b0 ^ cin;

  generate
    if (USE_JK) begin : g_jk
      logic jin, kin;
      assign jin     = a0 & b0;
      assign kin     = ~(a0 | b0);
      assign carry_d = (jin & ~cin) | (~kin & cin);

      // R8
      jk_matches_majority_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> carry_q == (($past(a0) & $past(b0)) | ($past(a0) & $past(cin)) | ($past(b0) & $past(cin))));
    end else begin : g_d
      assign carry_d = (a0 & b0) | (a0 & cin) | (b0 & cin);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_a     <= '0;
      reg_b     <= '0;
      carry_q   <= 1'b0;
      carry_out <= 1'b0;
      pos       <= '0;
    end else if (shift_en) begin
      reg_a   <= {ser_in, reg_a[WIDTH-1:1]};
      reg_b   <= {sum_bit, reg_b[WIDTH-1:1]};
      carry_q <= carry_d;
      pos     <= (pos == LAST) ? '0 : pos + 1'b1;
      if (pos == LAST) carry_out <= carry_d;
    end
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (reg_a == '0 && reg_b == '0 && carry_out == 1'b0 && pos == '0));

  // R2
  serial_entry_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> reg_a[WIDTH-1] == $past(ser_in));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> ($stable(reg_a) && $stable(reg_b) && $stable(carry_out) && $stable(pos)));

  // R4
  accum_shift_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> reg_b[WIDTH-2:0] == $past(reg_b[WIDTH-1:1]));

  // R5
  pass_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_en && pos == LAST) |=> pos == '0);

  // R6
  carry_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_en && pos != LAST) |=> $stable(carry_out));
endmodule

// File: tb/serial_accum_adder_test.sv
module serial_accum_adder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_en = 1'b0;
  logic ser_in = 1'b0;
  logic [3:0] a_d, b_d, a_j, b_j;
  logic co_d, co_j;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_accum_adder #(.WIDTH(4), .USE_JK(1'b0)) uut (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in),
    .reg_a(a_d), .reg_b(b_d), .carry_out(co_d));

  serial_accum_adder #(.WIDTH(4), .USE_JK(1'b1)) uut_jk (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in),
    .reg_a(a_j), .reg_b(b_j), .carry_out(co_j));

  function automatic logic [3:0] add4(input logic [3:0] x, input logic [3:0] y);
    return 4'((5'(x) + 5'(y)) & 5'h0f);
  endfunction

  function automatic logic cout4(input logic [3:0] x, input logic [3:0] y);
    logic [4:0] s;
    s = 5'(x) + 5'(y);
    return s[4];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic b);
    shift_en = en;
    ser_in   = b;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    rst = 1'b0;
    shift_en = 1'b0;
  endtask

  task automatic send(input logic [3:0] v);
    for (int i = 0; i < 4; i++) step(1'b1, v[i]);
  endtask

  task automatic chk_both(input string req, input logic [3:0] ea, input logic [3:0] eb, input logic ec);
    chk({req, " reg_a(D)"}, a_d, ea);
    chk({req, " reg_b(D)"}, b_d, eb);
    chk({req, " carry_out(D)"}, co_d, ec);
    chk({req, " reg_a(JK) R8"}, a_j, ea);
    chk({req, " reg_b(JK) R8"}, b_j, eb);
    chk({req, " carry_out(JK) R8"}, co_j, ec);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] acc, prev, op, sa, sb;
    void'($urandom(32'd7));
    @(negedge clk);

    // R1: reset state
    do_reset();
    chk_both("R1 reset", 4'd0, 4'd0, 1'b0);

    // R7 directed sequence
    send(4'b1011);
    chk_both("R2 first operand", 4'b1011, 4'b0000, 1'b0);
    send(4'b0010);
    chk_both("R4 after pass 2", 4'b0010, 4'b1011, 1'b0);
    send(4'b0000);
    chk_both("R7 twelve cycles", 4'b0000, 4'b1101, 1'b0);

    // R1: mid-pass reset restarts pass position
    send(4'b1111);
    step(1'b1, 1'b1);
    do_reset();
    chk_both("R1 mid-pass reset", 4'd0, 4'd0, 1'b0);
    send(4'b1111);
    send(4'b0001);
    send(4'b0000);
    chk_both("R6 wrap 15+1", 4'd0, 4'd0, 1'b1);

    // R4 R6 R8 exhaustive pairs
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        do_reset();
        send(4'(x));
        send(4'(y));
        send(4'd0);
        chk_both("R4 R6 exhaustive", 4'd0, add4(4'(x), 4'(y)), cout4(4'(x), 4'(y)));
      end
    end

    // R5 R6 R3 random running accumulation with idle gaps
    do_reset();
    acc = 4'd0;
    prev = 4'd0;
    for (int k = 0; k < 300; k++) begin
      op = 4'($urandom % 16);
      for (int i = 0; i < 4; i++) begin
        if (($urandom % 4) == 0) begin
          sa = a_d;
          sb = b_d;
          step(1'b0, 1'($urandom % 2));
          step(1'b0, 1'($urandom % 2));
          chk("R3 idle reg_a", a_d, sa);
          chk("R3 idle reg_b", b_d, sb);
        end
        step(1'b1, op[i]);
      end
      chk_both("R5 running sum", op, add4(acc, prev), cout4(acc, prev));
      acc = add4(acc, prev);
      prev = op;
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule